// File: doc/BRIEF.md
# Reciprocal Gated Frequency Meter

This block measures the frequency of a digital input against a free-running reference clock. A preset window is derived by counting reference cycles. The window that actually gates the counters opens and closes only on rising edges of the synchronized input, so it always spans a whole number of input periods. While it is open, two counters run side by side. One counts reference cycles and the other counts input periods. When it closes, both totals are captured together.

After each capture, a sequential divider computes the scaled ratio `SCALE * sigCount / refCount` by adding the reference total into an accumulator once per clock. The result is the input frequency in units of the reference frequency divided by `SCALE`. It appears on `quotient` with a one-cycle `resultValid` strobe. Captures that arrive while a division is still running are dropped. The input goes through a two-stage synchronizer before its edges are detected. Reset is synchronous and active high.

Top module: `recip_freq_meter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `quotient`, `refCount` and `sigCount` read 0 and `resultValid` reads 0.
- R2: The preset window toggles once every `PRESET_LIMIT + 1` reference cycles. A captured `refCount` therefore differs from `PRESET_LIMIT + 1` by less than one input period, measured in reference cycles.
- R3: The counting window opens and closes only on synchronized rising input edges. For an input with a constant period of P reference cycles, every capture satisfies `refCount == P * sigCount` exactly, and `sigCount` is nonzero.
- R4: Each result equals floor(`SCALE * sigCount / refCount`) of the capture that started the division. For a steady input of period P, that is floor(10000 / P) with the default `SCALE` of 10000.
- R5: `resultValid` is high for exactly one reference cycle per result. `quotient` changes only in that cycle and holds its value otherwise.
- R6: A capture taken while a division is in progress starts no new division and does not alter the running one. The next result still belongs to the earlier capture.
- R7: A division starts only from a capture in which both totals are nonzero. While the input has no rising edges, no capture is taken and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sigIn | input | 1 | Measured signal, asynchronous to `clk` |
| quotient | output | CNT_W | Last scaled frequency result |
| resultValid | output | 1 | One-cycle strobe marking a new `quotient` |
| refCount | output | CNT_W | Reference cycles counted in the last closed window |
| sigCount | output | CNT_W | Input periods counted in the last closed window |

## Verification
A window edge that is not tied to an input edge breaks the exact product `refCount == P * sigCount`. This shows at the ports at the next capture, roughly two preset half-periods after the fault. A divider that restarts on a capture arriving mid-division returns the later ratio first. The bench forces this case by switching the input period while a long division is running. A stuck or repeating strobe, or an off-by-one in the step test, shows up on the very next result as a wrong floor value or a strobe lasting two cycles.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  // Strobes sent from the divider control to the datapath
  typedef struct packed {
    logic load;    // latch operands, clear accumulator
    logic step;    // add divisor once, bump partial quotient
    logic finish;  // publish the partial quotient
  } div_cmd_t;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_t;

endpackage

// File: rtl/rfm_gate_counter.sv
module rfm_gate_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gateRise,
  input  logic         gateFall,
  input  logic         inc,
  output logic [W-1:0] heldVal
);

  logic [W-1:0] runVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      runVal  <= '0;
      heldVal <= '0;
    end else if (gateRise) begin
      runVal <= W'(1);
    end else if (gateFall) begin
      heldVal <= runVal;
    end else if (inc && (runVal != '1)) begin
      runVal <= runVal + W'(1);
    end
  end

endmodule

// File: rtl/rfm_datapath.sv
module rfm_datapath
  import rfm_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int PRESET_LIMIT = 1000,
  parameter int SCALE        = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sigIn,
  input  div_cmd_t         cmd,
  output logic             capPulse,
  output logic             capNonZero,
  output logic             canStep,
  output logic [CNT_W-1:0] refCount,
  output logic [CNT_W-1:0] sigCount,
  output logic [CNT_W-1:0] quotient,
  output logic [CNT_W-1:0] opDivisor,
  output logic             actualGate,
  output logic             risePulse
);

  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int DIV_W   = CNT_W + SCALE_W;
  localparam int PRE_W   = $clog2(PRESET_LIMIT + 1);

  // ---------------- input synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sigPrev;
  logic                   sigSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      sigPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], sigIn};
      sigPrev   <= sigSync;
    end
  end

  assign sigSync   = syncChain[SYNC_STAGES-1];
  assign risePulse = sigSync & ~sigPrev;

  // ---------------- preset window from the reference clock
  logic [PRE_W-1:0] presetCnt;
  logic             presetGate;

  always_ff @(posedge clk) begin
    if (rst) begin
      presetCnt  <= '0;
      presetGate <= 1'b0;
    end else if (presetCnt == PRE_W'(PRESET_LIMIT)) begin
      presetCnt  <= '0;
      presetGate <= ~presetGate;
    end else begin
      presetCnt <= presetCnt + PRE_W'(1);
    end
  end

  // ---------------- window re-timed to input edges
  logic gatePrev;
  logic gateRise;
  logic gateFall;

  always_ff @(posedge clk) begin
    if (rst) begin
      actualGate <= 1'b0;
      gatePrev   <= 1'b0;
      capPulse   <= 1'b0;
    end else begin
      if (risePulse) actualGate <= presetGate;
      gatePrev <= actualGate;
      capPulse <= gateFall;
    end
  end

  assign gateRise = actualGate & ~gatePrev;
  assign gateFall = ~actualGate & gatePrev;

  // the edge that closes the window is not counted as a new period
  logic sigInc;
  assign sigInc = actualGate & risePulse & presetGate;

  rfm_gate_counter #(.W(CNT_W)) u_refCtr (
    .clk      (clk),
    .rst      (rst),
    .gateRise (gateRise),
    .gateFall (gateFall),
    .inc      (actualGate),
    .heldVal  (refCount)
  );

  rfm_gate_counter #(.W(CNT_W)) u_sigCtr (
    .clk      (clk),
    .rst      (rst),
    .gateRise (gateRise),
    .gateFall (gateFall),
    .inc      (sigInc),
    .heldVal  (sigCount)
  );

  assign capNonZero = (refCount != '0) && (sigCount != '0);

  // ---------------- repeated-addition divider datapath
  logic [DIV_W-1:0] dividend;
  logic [DIV_W-1:0] acc;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] qRun;
  logic [DIV_W:0]   sumNext;

  assign sumNext   = {1'b0, acc} + {{(DIV_W + 1 - CNT_W){1'b0}}, divisor};
  assign canStep   = (sumNext <= {1'b0, dividend}) && (qRun != '1);
  assign opDivisor = divisor;

  always_ff @(posedge clk) begin
    if (rst) begin
      dividend <= '0;
      acc      <= '0;
      divisor  <= '0;
      qRun     <= '0;
      quotient <= '0;
    end else begin
      if (cmd.load) begin
        dividend <= DIV_W'(SCALE) * DIV_W'(sigCount);
        divisor  <= refCount;
        acc      <= '0;
        qRun     <= '0;
      end else if (cmd.step) begin
        acc  <= sumNext[DIV_W-1:0];
        qRun <= qRun + CNT_W'(1);
      end
      if (cmd.finish) quotient <= qRun;
    end
  end

endmodule

// File: rtl/rfm_control.sv
module rfm_control
  import rfm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     capPulse,
  input  logic     capNonZero,
  input  logic     canStep,
  output div_cmd_t cmd,
  output logic     busy,
  output logic     resultValid
);

  div_state_t state;

  always_comb begin
    cmd = '0;
    case (state)
      DIV_IDLE: cmd.load = capPulse & capNonZero;
      DIV_RUN: begin
        cmd.step   = canStep;
        cmd.finish = ~canStep;
      end
      default: cmd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= DIV_IDLE;
      resultValid <= 1'b0;
    end else begin
      resultValid <= cmd.finish;
      if (cmd.load)        state <= DIV_RUN;
      else if (cmd.finish) state <= DIV_IDLE;
    end
  end

  assign busy = (state == DIV_RUN);

endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
  import rfm_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter int PRESET_LIMIT = 1000,
  parameter int SCALE        = 10000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sigIn,
  output logic [CNT_W-1:0] quotient,
  output logic             resultValid,
  output logic [CNT_W-1:0] refCount,
  output logic [CNT_W-1:0] sigCount
);

  div_cmd_t         cmd;
  logic             capPulse;
  logic             capNonZero;
  logic             canStep;
  logic             busy;
  logic             actualGate;
  logic             risePulse;
  logic [CNT_W-1:0] opDivisor;

  rfm_datapath #(
    .CNT_W        (CNT_W),
    .PRESET_LIMIT (PRESET_LIMIT),
    .SCALE        (SCALE),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .sigIn      (sigIn),
    .cmd        (cmd),
    .capPulse   (capPulse),
    .capNonZero (capNonZero),
    .canStep    (canStep),
    .refCount   (refCount),
    .sigCount   (sigCount),
    .quotient   (quotient),
    .opDivisor  (opDivisor),
    .actualGate (actualGate),
    .risePulse  (risePulse)
  );

  rfm_control u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .capPulse    (capPulse),
    .capNonZero  (capNonZero),
    .canStep     (canStep),
    .cmd         (cmd),
    .busy        (busy),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             resultValid,
  input logic [CNT_W-1:0] quotient,
  input logic [CNT_W-1:0] refCount,
  input logic [CNT_W-1:0] sigCount,
  input logic             busy,
  input logic [CNT_W-1:0] opDivisor,
  input logic             actualGate,
  input logic             risePulse,
  input logic             capPulse,
  input logic             capNonZero
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid); // R5

  AST_VALID_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    (armed && resultValid) |-> $past(busy)); // R5

  AST_QUOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed && !resultValid) |-> $stable(quotient)); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (armed && busy && $past(busy)) |-> $stable(opDivisor)); // R6

  AST_GATE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (armed && !$stable(actualGate)) |-> $past(risePulse)); // R3

  AST_REF_COVERS_SIG: assert property (@(posedge clk) disable iff (rst)
    {1'b0, refCount} >= {sigCount, 1'b0}); // R3

  AST_START_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && busy && !$past(busy)) |-> $past(capPulse && capNonZero)); // R7

endmodule

bind recip_freq_meter rfm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .resultValid (resultValid),
  .quotient    (quotient),
  .refCount    (refCount),
  .sigCount    (sigCount),
  .busy        (busy),
  .opDivisor   (opDivisor),
  .actualGate  (actualGate),
  .risePulse   (risePulse),
  .capPulse    (capPulse),
  .capNonZero  (capNonZero)
);

// File: tb/test_recip_freq_meter.sv
module test_recip_freq_meter;

  localparam int PRESET = 1000;
  localparam int SCALE  = 10000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sigIn = 1'b0;
  logic [19:0] quotient;
  logic [19:0] refCount;
  logic [19:0] sigCount;
  logic        resultValid;

  always #10 clk = ~clk;  // 50 MHz

  recip_freq_meter i_recip_freq_meter (
    .clk         (clk),
    .rst         (rst),
    .sigIn       (sigIn),
    .quotient    (quotient),
    .resultValid (resultValid),
    .refCount    (refCount),
    .sigCount    (sigCount)
  );

  int checks = 0;
  int failures = 0;
  int periodCyc = 2;
  int expQ[$];
  bit ignoreResults = 1'b0;
  int resultCount = 0;
  bit prevValid = 1'b0;
  bit finished = 1'b0;
  int expVal;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // input generator: period in reference cycles, 0 stops the input
  initial begin
    forever begin
      if (periodCyc < 2) begin
        sigIn = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = periodCyc;
        sigIn = 1'b1;
        repeat (p / 2) @(negedge clk);
        sigIn = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  // monitor: pops expected results as strobes appear
  always @(negedge clk) begin
    if (rst) begin
      prevValid = 1'b0;
    end else begin
      if (prevValid) check(!resultValid, "R5 strobe width", int'(resultValid), 0);
      if (resultValid) begin
        resultCount++;
        if (!ignoreResults) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R6 unexpected result", int'(quotient), -1);
          end else begin
            expVal = expQ.pop_front();
            if (expVal >= 0)
              check(int'(quotient) == expVal, "R4 R6 quotient", int'(quotient), expVal);
          end
        end
      end
      prevValid = resultValid;
    end
  end

  task automatic waitDrain();
    for (int i = 0; i < 30000 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, "R4 result missing", expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic checkCapture(input int p);
    check(int'(refCount) == p * int'(sigCount), "R3 whole periods", int'(refCount), p * int'(sigCount));
    check(sigCount != 0, "R3 nonzero periods", int'(sigCount), 1);
    check(absDiff(int'(refCount), PRESET + 1) < p, "R2 window length", int'(refCount), PRESET + 1);
  endtask

  task automatic runPhase(input int p, input int n);
    periodCyc = p;
    expQ.push_back(-1);  // first result may span both periods
    for (int i = 0; i < n; i++) expQ.push_back(SCALE / p);
    waitDrain();
    checkCapture(p);
  endtask

  initial begin
    int rc;
    int rSnap;
    int sSnap;
    repeat (5) @(negedge clk);
    check(quotient == 0, "R1 quotient", int'(quotient), 0);
    check(refCount == 0, "R1 refCount", int'(refCount), 0);
    check(sigCount == 0, "R1 sigCount", int'(sigCount), 0);
    check(!resultValid, "R1 valid", int'(resultValid), 0);
    rst = 1'b0;

    // R6: period 2 gives a 5000-step division; switch period while it runs
    expQ.push_back(SCALE / 2);
    repeat (2600) @(negedge clk);
    checkCapture(2);
    periodCyc = 5;
    expQ.push_back(SCALE / 5);
    waitDrain();
    checkCapture(5);

    runPhase(10, 2);
    runPhase(7, 2);
    runPhase(3, 1);
    runPhase(13, 2);

    // R7: no input edges, no capture and no result
    ignoreResults = 1'b1;
    periodCyc = 0;
    repeat (2000) @(negedge clk);
    rc = resultCount;
    rSnap = int'(refCount);
    sSnap = int'(sigCount);
    repeat (6000) @(negedge clk);
    check(resultCount == rc, "R7 no result", resultCount, rc);
    check(int'(refCount) == rSnap, "R7 refCount held", int'(refCount), rSnap);
    check(int'(sigCount) == sSnap, "R7 sigCount held", int'(sigCount), sSnap);
    ignoreResults = 1'b0;

    // R1: reset after activity clears the outputs
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(quotient == 0, "R1 quotient after run", int'(quotient), 0);
    check(refCount == 0, "R1 refCount after run", int'(refCount), 0);
    check(sigCount == 0, "R1 sigCount after run", int'(sigCount), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule